// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns transitions on a group of external input lines into interrupt requests. Each line passes through a synchroniser and an edge detector. Software selects whether a line reacts to rising edges, falling edges or both. A qualifying edge on an unmasked line is held in a sticky pending bit until software clears it by writing a 1 to that bit.

Software can also raise an interrupt without any external edge. It writes a 1 into a software-trigger bit that currently reads 0. That bit then stays set until the matching pending bit is cleared.

Only lines 0 to 22 and line 30 exist. Every other bit position is inert in every register. The host reaches the block through a plain 32-bit register bus: a single-cycle write strobe and a combinational read-data path. The block drives one request output per line and a single combined request output.

Top module: `xirq_ctrl`

## Requirements
- R1: A rising edge on an implemented, unmasked line that has its rising-select bit set sets its pending bit. The line's request output goes high on the third rising clock edge after the input changes, and is still low after the second.
- R2: A line with only its falling-select bit set reacts to falling edges and not to rising ones. A line with both select bits set reacts to either edge.
- R3: A falling edge whose detection cycle coincides with a bus write to the falling-select register (offset 0x0C) does not set a pending bit.
- R4: A hardware edge on a line whose mask bit is 0 leaves its pending bit at 0.
- R5: Writing 1 to a software-trigger bit (offset 0x10) that reads 0 sets that bit, provided the line is unmasked. If the line is unmasked, the same write also sets the pending bit on the committing clock edge. If the line is masked, the software-trigger bit is set and the pending bit stays 0.
- R6: A software-trigger bit ignores writes of 0. A write of 1 to an already-set software-trigger bit does not set the pending bit. The software-trigger bit is cleared when a 1 is written to the same bit of the pending register.
- R7: The pending register (offset 0x14) clears a bit when 1 is written to it, and writing 0 has no effect. If a new edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: Bits 31 and 29 to 23 read as 0 and ignore writes in all five registers. Activity on those input lines never sets a pending bit.
- R9: After reset, all five registers read 0, and `irq_lines` and `irq_any` are 0.
- R10: `irq_lines` is the pending register ANDed with the mask register, and `irq_any` is the OR of `irq_lines`. Masking a pending line hides its request but keeps the pending bit.
- R11: The mask, rising-select and falling-select registers sit at offsets 0x00, 0x08 and 0x0C and are read/write on implemented bits. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| line_in | input | 32 | Asynchronous external lines, bit n is line n |
| irq_lines | output | 32 | Per-line interrupt requests |
| irq_any | output | 1 | OR of all per-line requests |

## Verification
A hardware edge takes three register stages to reach the outputs: two synchroniser flops, then the pending flop. The bench therefore changes `line_in` just after a clock edge, shows that the request is still low after two edges, and samples the request after the third. A bus write commits on the edge that ends its strobe cycle, so a software trigger or a clear is visible right after that edge. The dropped-falling-edge case places the falling-select write exactly in the cycle between the second and third edge after the line falls. Every result is queued as an expected item before it is due, and a monitor compares each item on the falling clock edge, away from the edge that updates the design.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    parameter int unsigned DW = 32;
    parameter int unsigned AW = 8;

    // Lines 0..22 and 30 exist
    localparam logic [DW-1:0] LINE_IMPL = 32'h407F_FFFF;

    localparam logic [AW-1:0] OFS_MASK = 8'h00;
    localparam logic [AW-1:0] OFS_RISE = 8'h08;
    localparam logic [AW-1:0] OFS_FALL = 8'h0C;
    localparam logic [AW-1:0] OFS_SWT  = 8'h10;
    localparam logic [AW-1:0] OFS_PEND = 8'h14;

    typedef enum logic [2:0] {
        RSEL_MASK, RSEL_RISE, RSEL_FALL, RSEL_SWT, RSEL_PEND, RSEL_NONE
    } rsel_e;

    typedef struct packed {
        logic          wr_mask;
        logic          wr_rise;
        logic          wr_fall;
        logic          wr_swt;
        logic          wr_pend;
        logic [DW-1:0] data;
    } bus_wr_t;

    typedef struct packed {
        logic [DW-1:0] mask;
        logic [DW-1:0] rise;
        logic [DW-1:0] fall;
        logic [DW-1:0] swt;
    } cfg_t;

    function automatic rsel_e decode_ofs(input logic [AW-1:0] a);
        case (a)
            OFS_MASK: return RSEL_MASK;
            OFS_RISE: return RSEL_RISE;
            OFS_FALL: return RSEL_FALL;
            OFS_SWT:  return RSEL_SWT;
            OFS_PEND: return RSEL_PEND;
            default:  return RSEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/xirq_edge_det.sv
module xirq_edge_det #(
    parameter int unsigned         W      = 32,
    parameter int unsigned         STAGES = 2,
    parameter logic [W-1:0]        IMPL   = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] line_in,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar g = 0; g < W; g++) begin : g_line
        if (IMPL[g]) begin : g_impl
            logic [STAGES-1:0] sh;
            logic              prev;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sh   <= '0;
                    prev <= 1'b0;
                end else begin
                    sh   <= {sh[STAGES-2:0], line_in[g]};
                    prev <= sh[LAST];
                end
            end
            assign rise_o[g] =  sh[LAST] & ~prev;
            assign fall_o[g] = ~sh[LAST] &  prev;
        end else begin : g_rsvd
            assign rise_o[g] = 1'b0;
            assign fall_o[g] = 1'b0;
        end
    end

endmodule

// File: rtl/xirq_cfg_regs.sv
module xirq_cfg_regs
    import xirq_pkg::*;
#(
    parameter logic [DW-1:0] IMPL = LINE_IMPL
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_wr_t       wr,
    output cfg_t          cfg,
    output logic [DW-1:0] sw_new
);

    logic [DW-1:0] wmask;
    logic [DW-1:0] clr_vec;

    assign wmask   = wr.data & IMPL;
    assign clr_vec = wr.wr_pend ? wmask : '0;
    // Only 0->1 transitions of the software-trigger bits count
    assign sw_new  = wr.wr_swt ? (wmask & ~cfg.swt) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (wr.wr_mask) cfg.mask <= wmask;
            if (wr.wr_rise) cfg.rise <= wmask;
            if (wr.wr_fall) cfg.fall <= wmask;
            cfg.swt <= (cfg.swt | sw_new) & ~clr_vec;
        end
    end

    a_r11_mask_rw: assert property (@(posedge clk) disable iff (rst)
        wr.wr_mask |=> cfg.mask == $past(wr.data & IMPL));

    a_r6_swt_hold: assert property (@(posedge clk) disable iff (rst)
        !wr.wr_pend |=> (($past(cfg.swt) & ~cfg.swt) == '0));

endmodule

// File: rtl/xirq_pending.sv
module xirq_pending
    import xirq_pkg::*;
#(
    parameter logic [DW-1:0] IMPL = LINE_IMPL
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_wr_t       wr,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] rise_sel,
    input  logic [DW-1:0] fall_sel,
    input  logic [DW-1:0] rise_e,
    input  logic [DW-1:0] fall_e,
    input  logic [DW-1:0] sw_new,
    output logic [DW-1:0] pend
);

    logic [DW-1:0] hw_hit;
    logic [DW-1:0] set_vec;
    logic [DW-1:0] clr_vec;
    logic          fall_block;

    // A falling edge seen while the falling-select register is written is dropped
    assign fall_block = wr.wr_fall;
    assign hw_hit  = (rise_e & rise_sel) | (fall_e & fall_sel & {DW{~fall_block}});
    assign set_vec = (hw_hit | sw_new) & mask & IMPL;
    assign clr_vec = wr.wr_pend ? (wr.data & IMPL) : '0;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_vec) | set_vec;
    end

    a_r5_sw_sets: assert property (@(posedge clk) disable iff (rst)
        |(sw_new & mask) |=> (($past(sw_new & mask) & ~pend) == '0));

    a_r7_w1c: assert property (@(posedge clk) disable iff (rst)
        wr.wr_pend |=> ((pend & $past(wr.data & IMPL & ~(rise_e | fall_e | sw_new))) == '0));

    a_r3_fall_drop: assert property (@(posedge clk) disable iff (rst)
        (wr.wr_fall && rise_e == '0) |=> ((pend & ~$past(pend)) == '0));

    a_r4_masked: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((pend & ~$past(pend) & ~$past(mask)) == '0));

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wen,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] line_in,
    output logic [DW-1:0] irq_lines,
    output logic          irq_any
);

    rsel_e         sel;
    bus_wr_t       wr;
    cfg_t          cfg;
    logic [DW-1:0] sw_new;
    logic [DW-1:0] rise_e;
    logic [DW-1:0] fall_e;
    logic [DW-1:0] pend;

    assign sel = decode_ofs(bus_addr);

    always_comb begin
        wr         = '0;
        wr.data    = bus_wdata;
        wr.wr_mask = bus_wen && sel == RSEL_MASK;
        wr.wr_rise = bus_wen && sel == RSEL_RISE;
        wr.wr_fall = bus_wen && sel == RSEL_FALL;
        wr.wr_swt  = bus_wen && sel == RSEL_SWT;
        wr.wr_pend = bus_wen && sel == RSEL_PEND;
    end

    xirq_edge_det #(
        .W(DW), .STAGES(SYNC_STAGES), .IMPL(LINE_IMPL)
    ) u_edge (
        .clk(clk), .rst(rst), .line_in(line_in),
        .rise_o(rise_e), .fall_o(fall_e)
    );

    xirq_cfg_regs #(.IMPL(LINE_IMPL)) u_cfg (
        .clk(clk), .rst(rst), .wr(wr), .cfg(cfg), .sw_new(sw_new)
    );

    xirq_pending #(.IMPL(LINE_IMPL)) u_pend (
        .clk(clk), .rst(rst), .wr(wr),
        .mask(cfg.mask), .rise_sel(cfg.rise), .fall_sel(cfg.fall),
        .rise_e(rise_e), .fall_e(fall_e), .sw_new(sw_new), .pend(pend)
    );

    always_comb begin
        case (sel)
            RSEL_MASK: bus_rdata = cfg.mask;
            RSEL_RISE: bus_rdata = cfg.rise;
            RSEL_FALL: bus_rdata = cfg.fall;
            RSEL_SWT:  bus_rdata = cfg.swt;
            RSEL_PEND: bus_rdata = pend;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_lines = pend & cfg.mask;
    assign irq_any   = |irq_lines;

    a_r10_any_follows: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (irq_any == (irq_lines != '0)));

endmodule

// File: tb/tb_xirq_ctrl.sv
`timescale 1ns/1ps
module tb_xirq_ctrl;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wen;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] line_in;
    logic [31:0] irq_lines;
    logic        irq_any;

    always #(CLK_NS/2) clk = ~clk;

    xirq_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in),
        .irq_lines(irq_lines), .irq_any(irq_any)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 irq_lines, 2 irq_any
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    logic  probe = 1'b0;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;

    localparam logic [7:0] A_MASK = 8'h00, A_RISE = 8'h08, A_FALL = 8'h0C,
                           A_SWT = 8'h10, A_PEND = 8'h14;

    // Monitor: compares queued expectations on the falling edge
    always @(negedge clk) begin
        if (probe && q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = irq_lines;
                default: act = {31'b0, irq_any};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: pushes an expectation and strobes the monitor
    task automatic chk(input int kind, input logic [7:0] addr,
                       input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        bus_addr = addr;
        q.push_back(it);
        probe = 1'b1;
        @(negedge clk);
        #1 probe = 1'b0;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        bus_addr  = addr;
        bus_wdata = data;
        bus_wen   = 1'b1;
        step(1);
        bus_wen   = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0; line_in = '0;
        step(3);
        rst = 1'b0;
        step(1);

        // R9 reset state
        chk(0, A_MASK, 32'h0, "R9 mask");
        chk(0, A_RISE, 32'h0, "R9 rise");
        chk(0, A_FALL, 32'h0, "R9 fall");
        chk(0, A_SWT,  32'h0, "R9 swt");
        chk(0, A_PEND, 32'h0, "R9 pend");
        chk(2, A_PEND, 32'h0, "R9 irq_any");

        // R11 / R8 register map and reserved bits
        wr(A_MASK, 32'hFFFF_FFFF);
        chk(0, A_MASK, 32'h407F_FFFF, "R8 mask reserved");
        wr(A_RISE, 32'h4000_0003);
        wr(A_FALL, 32'h0000_0006);
        chk(0, A_RISE, 32'h4000_0003, "R11 rise rw");
        chk(0, A_FALL, 32'h0000_0006, "R11 fall rw");
        chk(0, 8'h04, 32'h0, "R11 unmapped offset");

        // R1 rise on line 0, latency
        step(1);
        line_in[0] = 1'b1;
        step(2);
        chk(1, A_PEND, 32'h0, "R1 not yet after two edges");
        step(1);
        chk(1, A_PEND, 32'h1, "R1 request on third edge");
        chk(0, A_PEND, 32'h1, "R1 pending");
        wr(A_PEND, 32'h1);
        chk(0, A_PEND, 32'h0, "R7 cleared");

        // R2 rise-only line ignores falling edge
        line_in[0] = 1'b0;
        step(4);
        chk(0, A_PEND, 32'h0, "R2 rise-only ignores fall");

        // R2 both edges on line 30
        wr(A_FALL, 32'h4000_0006);
        line_in[30] = 1'b1;
        step(4);
        chk(0, A_PEND, 32'h4000_0000, "R2 both: rise");
        wr(A_PEND, 32'h4000_0000);
        line_in[30] = 1'b0;
        step(4);
        chk(0, A_PEND, 32'h4000_0000, "R2 both: fall");
        wr(A_PEND, 32'h4000_0000);

        // R2 fall-only line 2
        line_in[2] = 1'b1;
        step(4);
        chk(0, A_PEND, 32'h0, "R2 fall-only ignores rise");
        line_in[2] = 1'b0;
        step(4);
        chk(0, A_PEND, 32'h4, "R2 fall-only fall");
        wr(A_PEND, 32'h4);

        // R3 falling edge dropped during falling-select write
        line_in[2] = 1'b1;
        step(4);
        step(1);
        line_in[2] = 1'b0;
        step(2);
        wr(A_FALL, 32'h4000_0006);
        step(3);
        chk(0, A_PEND, 32'h0, "R3 fall dropped on write");

        // R4 masked line
        wr(A_MASK, 32'h4000_0000);
        line_in[1] = 1'b1;
        step(4);
        chk(0, A_PEND, 32'h0, "R4 masked edge");
        wr(A_MASK, 32'hFFFF_FFFF);

        // R5 software trigger
        wr(A_SWT, 32'h20);
        chk(0, A_PEND, 32'h20, "R5 sw sets pending");
        chk(0, A_SWT,  32'h20, "R5 sw bit reads 1");
        chk(2, A_PEND, 32'h1,  "R5 irq_any");

        // R6 hold, clear via pending
        wr(A_SWT, 32'h0);
        chk(0, A_SWT, 32'h20, "R6 write 0 ignored");
        wr(A_PEND, 32'h20);
        chk(0, A_PEND, 32'h0, "R6 pend cleared");
        chk(0, A_SWT,  32'h0, "R6 sw cleared with pending");

        // R5 masked software trigger
        wr(A_MASK, 32'h407F_FFDF);
        wr(A_SWT, 32'h20);
        chk(0, A_PEND, 32'h0,  "R5 masked sw no pending");
        chk(0, A_SWT,  32'h20, "R5 masked sw bit set");
        wr(A_MASK, 32'hFFFF_FFFF);
        wr(A_SWT, 32'h20);
        chk(0, A_PEND, 32'h0, "R6 rewrite of set bit no trigger");
        wr(A_PEND, 32'h20);
        chk(0, A_SWT, 32'h0, "R6 cleared via pending w1c");

        // R7 write 0 no effect, set wins over clear
        wr(A_SWT, 32'h80);
        wr(A_PEND, 32'h0);
        chk(0, A_PEND, 32'h80, "R7 write 0 no effect");
        step(1);
        line_in[0] = 1'b1;
        step(2);
        wr(A_PEND, 32'h1);
        chk(0, A_PEND, 32'h81, "R7 set wins over clear");
        wr(A_PEND, 32'hFFFF_FFFF);
        chk(0, A_PEND, 32'h0, "R7 clear all");

        // R10 output masking
        wr(A_SWT, 32'h80);
        chk(1, A_PEND, 32'h80, "R10 irq_lines");
        wr(A_MASK, 32'h407F_FF7F);
        chk(1, A_PEND, 32'h0,  "R10 masked request hidden");
        chk(2, A_PEND, 32'h0,  "R10 irq_any low");
        chk(0, A_PEND, 32'h80, "R10 pending kept");
        wr(A_MASK, 32'hFFFF_FFFF);
        chk(1, A_PEND, 32'h80, "R10 request back");
        wr(A_PEND, 32'hFFFF_FFFF);

        // R8 reserved bits in swt/pend and reserved inputs
        wr(A_SWT, 32'hFF80_0000);
        chk(0, A_SWT,  32'h4000_0000, "R8 swt reserved");
        chk(0, A_PEND, 32'h4000_0000, "R8 pend reserved");
        wr(A_PEND, 32'hFFFF_FFFF);
        chk(0, A_SWT, 32'h0, "R8 swt cleared");
        wr(A_RISE, 32'hFFFF_FFFF);
        chk(0, A_RISE, 32'h407F_FFFF, "R8 rise reserved");
        line_in[25] = 1'b1;
        line_in[31] = 1'b1;
        step(4);
        chk(0, A_PEND, 32'h0, "R8 reserved line inert");

        step(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule